// File: doc/BRIEF.md
# Programmable Reference Divider with Test-Mode Output Steering

This block divides a reference clock by a power of two chosen from eight settings, producing the square-wave comparison clock that a phase detector compares against the divided oscillator. A three-bit ratio select picks a division of 2, 4, 8 up to 256. A new select value is held back until the current output period has finished. This keeps every output period whole while software retunes.

The same block also decodes the test controls. When the test flag is clear, the charge pump runs under the phase detector, the lock pin reports the lock detector, and the three port pins follow their control bits. When the test flag is set, the two low port bits become a mode code instead. That code can force the charge pump to sink, force it to source, or switch it off, and each of these also overrides the lock pin. The fourth code steers the comparison clock and the halved programmable-divider output onto two of the port pins. The drive-disable bit and the current-select bit pass through unchanged in every mode. The lock pin and the port pins are open-drain, so each is modelled as an active-high pull-down enable.

The divider is a three-state machine. ST_START is entered on reset and leaves after one cycle, loading the ratio select. ST_HIGH holds the output high for half a period and then moves to ST_LOW. ST_LOW holds the output low for half a period and then moves back to ST_HIGH. That ST_LOW to ST_HIGH move is the period boundary, and it reloads the ratio select.

Top module: `refdiv_testmux`

## Requirements
- R1: While `rst_n` is low, `fcomp` is 0. At the first rising clock edge after reset is released, the machine leaves ST_START and `fcomp` goes high.
- R2: With `r_sel` = k (an unsigned binary value 0..7, bit 2 most significant), `fcomp` stays high for 2^k reference cycles and then low for 2^k cycles. The period is therefore 2^(k+1).
- R3: A change to `r_sel` in the middle of a period leaves that period's high and low lengths unchanged. The new value is loaded at the next rising edge of `fcomp`.
- R4: With `t0` = 0, `cp_cmd` is 2'b00 (normal), `lock_pd` is the inverse of `lock_raw` (pull down when out of lock), and `port_pd` equals `p_bits`.
- R5: With `t0` = 1 and `p_bits[1:0]` = 2'b00, `cp_cmd` is 2'b01 (force sink) and `lock_pd` is 1.
- R6: With `t0` = 1 and `p_bits[1:0]` = 2'b01, `cp_cmd` is 2'b10 (force source) and `lock_pd` is 0.
- R7: With `t0` = 1 and `p_bits[1:0]` = 2'b10, `cp_cmd` is 2'b11 (pump off, high impedance) and `lock_pd` is 1.
- R8: With `t0` = 1 and `p_bits[1:0]` = 2'b11, `port_pd[1]` carries `fcomp` and `port_pd[0]` carries `fpd_half`. `port_pd[2]` equals `p_bits[2]`, `cp_cmd` is 2'b00, and `lock_pd` is the inverse of `lock_raw`.
- R9: In every mode, `drive_en` is the inverse of `os_bit` and `cp_hi_current` equals `c0_bit`.
- R10: With `t0` = 1 and `p_bits[1:0]` set to 2'b00, 2'b01 or 2'b10, `port_pd` equals `p_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| r_sel | input | 3 | Ratio select; the division is 2^(r_sel+1) |
| t0 | input | 1 | Test flag |
| p_bits | input | 3 | Port control bits; bits 1:0 are also the test mode code |
| os_bit | input | 1 | Drive disable |
| c0_bit | input | 1 | Charge-pump current select |
| fpd_half | input | 1 | Programmable-divider output halved |
| lock_raw | input | 1 | Lock detector flag, 1 = locked |
| fcomp | output | 1 | Comparison clock, registered |
| cp_cmd | output | 2 | Charge-pump command: 00 normal, 01 sink, 10 source, 11 off |
| cp_hi_current | output | 1 | High pump current selected |
| drive_en | output | 1 | Varactor drive enabled |
| lock_pd | output | 1 | Lock pin pull-down enable |
| port_pd | output | 3 | Port pin pull-down enables |

## Verification
`fcomp` comes from a register. It changes only on a rising edge and is sampled on the falling edge that follows. A change to `r_sel` made at a falling edge is loaded at the first ST_LOW to ST_HIGH move after that edge. Phase lengths are therefore counted from the first falling edge at which `fcomp` is seen high. The decode and steering outputs are combinational, so they are checked one time unit after the inputs are driven at a falling edge, well before the next rising edge can move `fcomp`.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [1:0] {
        CP_NORMAL = 2'b00,
        CP_SINK   = 2'b01,
        CP_SOURCE = 2'b10,
        CP_OFF    = 2'b11
    } cp_cmd_e;

    typedef enum logic [2:0] {
        TM_NORMAL,
        TM_SINK,
        TM_SOURCE,
        TM_OFF,
        TM_ROUTE
    } test_mode_e;

    typedef enum logic [1:0] {
        ST_START,
        ST_HIGH,
        ST_LOW
    } phase_e;

endpackage

// File: rtl/refdiv_phase_fsm.sv
module refdiv_phase_fsm
    import refdiv_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    output logic             fcomp_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    phase_e             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [SEL_W-1:0]   sel_q;
    logic [CNT_W-1:0]   half_m1;
    logic               last;
    logic               load;
    logic               fcomp_q;

    assign half_m1 = CNT_W'((32'd1 << sel_q) - 32'd1);
    assign last    = (cnt_q == half_m1);

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and load strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_START: begin
                state_d = ST_HIGH;
                load    = 1'b1;
            end
            ST_HIGH: begin
                if (last) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (last) begin
                    state_d = ST_HIGH;
                    load    = 1'b1;
                end
            end
            default: state_d = ST_START;
        endcase
    end

    // half-period counter, active ratio and registered output
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sel_q   <= '0;
            fcomp_q <= 1'b0;
        end else begin
            if (state_q == ST_START || last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (load) sel_q <= sel_in;
            fcomp_q <= (state_d == ST_HIGH);
        end
    end

    assign fcomp_o = fcomp_q;

endmodule

// File: rtl/refdiv_mode_decode.sv
module refdiv_mode_decode
    import refdiv_pkg::*;
(
    input  logic       t0,
    input  logic [1:0] code,
    input  logic       lock_raw,
    output cp_cmd_e    cp_cmd,
    output logic       lock_pd,
    output logic       route_en
);
    test_mode_e mode;

    always_comb begin
        if (!t0) begin
            mode = TM_NORMAL;
        end else begin
            unique case (code)
                2'b00:   mode = TM_SINK;
                2'b01:   mode = TM_SOURCE;
                2'b10:   mode = TM_OFF;
                default: mode = TM_ROUTE;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            TM_SINK: begin
                cp_cmd  = CP_SINK;
                lock_pd = 1'b1;
            end
            TM_SOURCE: begin
                cp_cmd  = CP_SOURCE;
                lock_pd = 1'b0;
            end
            TM_OFF: begin
                cp_cmd  = CP_OFF;
                lock_pd = 1'b1;
            end
            default: begin
                cp_cmd  = CP_NORMAL;
                lock_pd = ~lock_raw;
            end
        endcase
        route_en = (mode == TM_ROUTE);
    end

endmodule

// File: rtl/refdiv_port_route.sv
module refdiv_port_route #(
    parameter int NPORT = 3
) (
    input  logic [NPORT-1:0] p_bits,
    input  logic             route_en,
    input  logic             fcomp,
    input  logic             fpd_half,
    output logic [NPORT-1:0] port_pd
);
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        if (i == 0) begin : g_p0
            assign port_pd[i] = route_en ? fpd_half : p_bits[i];
        end else if (i == 1) begin : g_p1
            assign port_pd[i] = route_en ? fcomp : p_bits[i];
        end else begin : g_pn
            assign port_pd[i] = p_bits[i];
        end
    end

endmodule

// File: rtl/refdiv_testmux.sv
module refdiv_testmux
    import refdiv_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int NPORT = 3
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             t0,
    input  logic [NPORT-1:0] p_bits,
    input  logic             os_bit,
    input  logic             c0_bit,
    input  logic             fpd_half,
    input  logic             lock_raw,
    output logic             fcomp,
    output logic [1:0]       cp_cmd,
    output logic             cp_hi_current,
    output logic             drive_en,
    output logic             lock_pd,
    output logic [NPORT-1:0] port_pd
);
    cp_cmd_e cmd;
    logic    route_en;

    refdiv_phase_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .sel_in  (r_sel),
        .fcomp_o (fcomp)
    );

    refdiv_mode_decode u_dec (
        .t0       (t0),
        .code     (p_bits[1:0]),
        .lock_raw (lock_raw),
        .cp_cmd   (cmd),
        .lock_pd  (lock_pd),
        .route_en (route_en)
    );

    refdiv_port_route #(.NPORT(NPORT)) u_route (
        .p_bits   (p_bits),
        .route_en (route_en),
        .fcomp    (fcomp),
        .fpd_half (fpd_half),
        .port_pd  (port_pd)
    );

    assign cp_cmd        = cmd;
    assign cp_hi_current = c0_bit;
    assign drive_en      = ~os_bit;

endmodule

// File: rtl/refdiv_testmux_chk.sv
module refdiv_testmux_chk #(
    parameter int SEL_W = 3,
    parameter int NPORT = 3
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic [SEL_W-1:0] r_sel,
    input logic             t0,
    input logic [NPORT-1:0] p_bits,
    input logic             os_bit,
    input logic             c0_bit,
    input logic             fpd_half,
    input logic             lock_raw,
    input logic             fcomp,
    input logic [1:0]       cp_cmd,
    input logic             cp_hi_current,
    input logic             drive_en,
    input logic             lock_pd,
    input logic [NPORT-1:0] port_pd
);
    p_normal_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !t0 |-> (cp_cmd == 2'b00 && lock_pd == !lock_raw && port_pd == p_bits));

    p_sink_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (t0 && p_bits[1:0] == 2'b00) |-> (cp_cmd == 2'b01 && lock_pd));

    p_source_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (t0 && p_bits[1:0] == 2'b01) |-> (cp_cmd == 2'b10 && !lock_pd));

    p_off_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (t0 && p_bits[1:0] == 2'b10) |-> (cp_cmd == 2'b11 && lock_pd));

    p_route_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (t0 && p_bits[1:0] == 2'b11) |-> (port_pd[1] == fcomp && port_pd[0] == fpd_half));

    p_pass_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (drive_en == !os_bit) && (cp_hi_current == c0_bit));

    p_ports_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (t0 && p_bits[1:0] != 2'b11) |-> (port_pd == p_bits));

endmodule

bind refdiv_testmux refdiv_testmux_chk #(.SEL_W(SEL_W), .NPORT(NPORT)) u_chk (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .r_sel         (r_sel),
    .t0            (t0),
    .p_bits        (p_bits),
    .os_bit        (os_bit),
    .c0_bit        (c0_bit),
    .fpd_half      (fpd_half),
    .lock_raw      (lock_raw),
    .fcomp         (fcomp),
    .cp_cmd        (cp_cmd),
    .cp_hi_current (cp_hi_current),
    .drive_en      (drive_en),
    .lock_pd       (lock_pd),
    .port_pd       (port_pd)
);

// File: tb/refdiv_testmux_bench.sv
module refdiv_testmux_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] r_sel   = 3'd0;
    logic       t0      = 1'b0;
    logic [2:0] p_bits  = 3'd0;
    logic       os_bit  = 1'b0;
    logic       c0_bit  = 1'b0;
    logic       fpd_half = 1'b0;
    logic       lock_raw = 1'b0;
    logic       fcomp;
    logic [1:0] cp_cmd;
    logic       cp_hi_current;
    logic       drive_en;
    logic       lock_pd;
    logic [2:0] port_pd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    refdiv_testmux u_refdiv_testmux (
        .clk_ref       (clk_ref),
        .rst_n         (rst_n),
        .r_sel         (r_sel),
        .t0            (t0),
        .p_bits        (p_bits),
        .os_bit        (os_bit),
        .c0_bit        (c0_bit),
        .fpd_half      (fpd_half),
        .lock_raw      (lock_raw),
        .fcomp         (fcomp),
        .cp_cmd        (cp_cmd),
        .cp_hi_current (cp_hi_current),
        .drive_en      (drive_en),
        .lock_pd       (lock_pd),
        .port_pd       (port_pd)
    );

    always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns at the falling edge where fcomp is first seen high
    task automatic wait_rise();
        bit prev = fcomp;
        forever begin
            @(negedge clk_ref);
            if (!prev && fcomp) break;
            prev = fcomp;
        end
    endtask

    // called at the falling edge of the first high cycle
    task automatic measure(output int hi, output int lo);
        hi = 1;
        lo = 0;
        forever begin
            @(negedge clk_ref);
            if (fcomp) hi++;
            else break;
        end
        lo = 1;
        forever begin
            @(negedge clk_ref);
            if (!fcomp) lo++;
            else break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog R1..all actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int hi;
        int lo;
        // R1: reset state
        repeat (3) @(negedge clk_ref);
        check(fcomp == 1'b0, "R1 fcomp in reset", int'(fcomp), 0);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check(fcomp == 1'b1, "R1 fcomp after first edge", int'(fcomp), 1);

        // R2: every ratio setting
        for (int k = 0; k < 8; k++) begin
            r_sel = 3'(k);
            wait_rise();
            measure(hi, lo);
            check(hi == (1 << k), $sformatf("R2 high length sel=%0d", k), hi, 1 << k);
            check(lo == (1 << k), $sformatf("R2 low length sel=%0d", k), lo, 1 << k);
        end

        // R3: change mid-period, effect only at next boundary
        r_sel = 3'd2;
        wait_rise();
        r_sel = 3'd5;
        measure(hi, lo);
        check(hi == 4, "R3 current period high kept", hi, 4);
        check(lo == 4, "R3 current period low kept", lo, 4);
        measure(hi, lo);
        check(hi == 32, "R3 next period high new", hi, 32);
        check(lo == 32, "R3 next period low new", lo, 32);

        // R4..R10: exhaustive sweep of decode and steering inputs
        r_sel = 3'd0;
        for (int v = 0; v < 256; v++) begin
            logic [1:0] e_cmd;
            logic       e_lock;
            logic [2:0] e_port;
            string      tag;
            @(negedge clk_ref);
            t0       = v[0];
            p_bits   = v[3:1];
            lock_raw = v[4];
            os_bit   = v[5];
            c0_bit   = v[6];
            fpd_half = v[7];
            #1;
            e_port = p_bits;
            if (!t0) begin
                e_cmd = 2'b00; e_lock = !lock_raw; tag = "R4";
            end else begin
                case (p_bits[1:0])
                    2'b00: begin e_cmd = 2'b01; e_lock = 1'b1; tag = "R5"; end
                    2'b01: begin e_cmd = 2'b10; e_lock = 1'b0; tag = "R6"; end
                    2'b10: begin e_cmd = 2'b11; e_lock = 1'b1; tag = "R7"; end
                    default: begin
                        e_cmd = 2'b00; e_lock = !lock_raw; tag = "R8";
                        e_port = {p_bits[2], fcomp, fpd_half};
                    end
                endcase
            end
            check(cp_cmd == e_cmd, {tag, " cp_cmd"}, int'(cp_cmd), int'(e_cmd));
            check(lock_pd == e_lock, {tag, " lock_pd"}, int'(lock_pd), int'(e_lock));
            if (t0 && p_bits[1:0] != 2'b11)
                check(port_pd == e_port, "R10 ports in forced modes", int'(port_pd), int'(e_port));
            else
                check(port_pd == e_port, {tag, " ports"}, int'(port_pd), int'(e_port));
            check(drive_en == !os_bit, "R9 drive_en", int'(drive_en), int'(!os_bit));
            check(cp_hi_current == c0_bit, "R9 current select", int'(cp_hi_current), int'(c0_bit));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule